// File: doc/BRIEF.md
# PWM Fault Protection Channel

This block watches a small group of external fault pins. When one of them becomes active it forces the matching PWM output pair into its safe inactive state. Each pin is first compared with a programmable active level. It then passes through a two-stage synchronizer and an optional sample-and-agree glitch filter. The result is latched into a fault flag, which software clears by writing a one. A flag can also raise a shared interrupt line.

Each fault has one of three clearing policies, and a policy decides when its latched fault condition goes away:
- **Automatic:** the condition ends when the filtered input goes inactive.
- **Manual:** the condition ends when software writes a flag clear.
- **Manual-safe:** a flag clear is honoured only while the input is inactive.

Even after the condition has ended, the output disable is released only at a PWM cycle boundary that the fault's recovery setting selects. The half-cycle and full-cycle strobes come from the PWM counter. For very fast shutdown, a fault can also drive its disable straight from the raw pin through a combinational path, bypassing synchronizer, filter and latch.

Configuration arrives over a plain single-cycle write port (`wr_en`, `wr_addr`, `wr_data`). All outputs are level signals. There is no streaming interface, so there is no valid/ready handshake and no back-pressure.

Top module: `pwm_fault_guard`

## Requirements
- R1: Register 0 holds one level bit per fault, and the reset value is all ones. A bit value of 1 means a high pin is a fault, and 0 means a low pin is a fault.
- R2: When a fault is newly detected (filtered level goes active), its flag (`fault_flag[i]`) and its disable (`fault_off[i]`) both become 1 on the same clock edge. With the filter bypassed, this happens on the third rising edge after the pin changes.
- R3: Register 6 is write-one-to-clear for the flags, with bit i belonging to fault i. A zero bit leaves that flag unchanged. A flag never clears without such a write.
- R4: Register 1 holds a 2-bit clearing mode per fault, in bits [2i+1:2i]: 0 = automatic, 1 = manual, 2 = manual-safe. In automatic mode the disable is released at the next selected boundary after the input goes inactive, with no software write needed.
- R5: In manual mode, releasing the input does not re-enable the output. A flag clear ends the fault condition at once, even while the input is still active, and the disable then drops at the next selected boundary.
- R6: In manual-safe mode, a flag clear written while the filtered input is active is ignored: both the flag and the disable stay set.
- R7: Register 2 holds a 2-bit recovery field per fault, in bits [2i+1:2i], with reset value 3: bit 0 releases on `half_stb` and bit 1 releases on `full_stb`. With value 3, whichever strobe comes first releases the output. With value 0 the output stays disabled.
- R8: Register 5 holds the filter sample period in bits [7:0] and the sample count in bits [10:8]. A period of 0 bypasses the filter. Otherwise the filtered level changes only after count+1 consecutive disagreeing samples, taken one every period clocks, so shorter glitches are rejected.
- R9: Any write to register 5 clears the filter state (filtered level to inactive, sample counters to zero), so a fault that is still present is detected again as a new event.
- R10: Register 3 holds one combinational-path enable bit per fault. When the bit is set, an active raw pin drives `fault_off[i]` within the same cycle, without waiting for a clock edge. When it is clear, only the latched fault drives the disable.
- R11: Register 4 holds one interrupt-enable bit per fault. `fault_irq` is 1 exactly while some flag whose enable bit is set is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_in | input | NF | Raw fault pins |
| half_stb | input | 1 | One-cycle strobe at the PWM half-cycle point |
| full_stb | input | 1 | One-cycle strobe at the PWM full-cycle point |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | DW | Write data (11 bits by default) |
| fault_off | output | NF | Per-fault output pair disable |
| fault_flag | output | NF | Latched fault flags |
| fault_irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is re-detection of a fault that never went away: a still-active input whose flag has been cleared and which must raise a new event. The stimulus gets there in three steps:
1. Hold a filtered fault active in automatic mode and clear its flag.
2. Confirm that no new flag appears.
3. Rewrite the filter register, then observe that the flag returns after the filter has re-qualified the level.

Glitch rejection is reached by making a pulse deliberately shorter than count+1 sample periods.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam logic [2:0] ADR_LEVEL = 3'd0;
  localparam logic [2:0] ADR_MODE  = 3'd1;
  localparam logic [2:0] ADR_RECOV = 3'd2;
  localparam logic [2:0] ADR_COMB  = 3'd3;
  localparam logic [2:0] ADR_IEN   = 3'd4;
  localparam logic [2:0] ADR_FILT  = 3'd5;
  localparam logic [2:0] ADR_FLAG  = 3'd6;

  localparam logic [1:0] CLR_AUTO = 2'd0;
  localparam logic [1:0] CLR_MAN  = 2'd1;
  localparam logic [1:0] CLR_SAFE = 2'd2;
endpackage

// File: rtl/fpc_regs.sv
module fpc_regs
  import fpc_pkg::*;
#(
  parameter int NF    = 4,
  parameter int PER_W = 8,
  parameter int CNT_W = 3,
  parameter int DW    = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            wr_addr,
  input  logic [DW-1:0]         wr_data,
  output logic [NF-1:0]         level,
  output logic [NF-1:0][1:0]    mode,
  output logic [NF-1:0][1:0]    recov,
  output logic [NF-1:0]         comb_en,
  output logic [NF-1:0]         ien,
  output logic [PER_W-1:0]      period,
  output logic [CNT_W-1:0]      need,
  output logic                  filt_wr,
  output logic [NF-1:0]         flag_clr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level   <= '1;
      mode    <= '0;
      recov   <= '1;
      comb_en <= '0;
      ien     <= '0;
      period  <= '0;
      need    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_LEVEL: level   <= wr_data[NF-1:0];
        ADR_MODE:  mode    <= wr_data[2*NF-1:0];
        ADR_RECOV: recov   <= wr_data[2*NF-1:0];
        ADR_COMB:  comb_en <= wr_data[NF-1:0];
        ADR_IEN:   ien     <= wr_data[NF-1:0];
        ADR_FILT: begin
          period <= wr_data[PER_W-1:0];
          need   <= wr_data[PER_W +: CNT_W];
        end
        default: ;
      endcase
    end
  end

  assign filt_wr  = wr_en && (wr_addr == ADR_FILT);
  assign flag_clr = (wr_en && (wr_addr == ADR_FLAG)) ? wr_data[NF-1:0] : '0;
endmodule

// File: rtl/fpc_filter.sv
module fpc_filter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_act,
  input  logic             tick,
  input  logic             bypass,
  input  logic             clr,
  input  logic [CNT_W-1:0] need,
  output logic             act
);
  logic             s1, s2, fq;
  logic [CNT_W-1:0] agree;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      fq    <= 1'b0;
      agree <= '0;
    end else begin
      s1 <= raw_act;
      s2 <= s1;
      if (clr) begin
        fq    <= 1'b0;
        agree <= '0;
      end else if (tick) begin
        if (s2 != fq) begin
          if (agree == need) begin
            fq    <= s2;
            agree <= '0;
          end else begin
            agree <= agree + 1'b1;
          end
        end else begin
          agree <= '0;
        end
      end
    end
  end

  assign act = bypass ? s2 : fq;
endmodule

// File: rtl/fpc_latch.sv
module fpc_latch
  import fpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act,
  input  logic       raw_act,
  input  logic       comb_en,
  input  logic [1:0] mode,
  input  logic [1:0] recov,
  input  logic       clr,
  input  logic       half_stb,
  input  logic       full_stb,
  output logic       flag,
  output logic       hold,
  output logic       off
);
  logic prev, pend;
  logic rise, manual, safe, clr_ok, boundary;

  assign rise     = act & ~prev;
  assign manual   = (mode != CLR_AUTO);
  assign safe     = mode[1];
  assign clr_ok   = clr & ~(safe & act);
  assign boundary = (half_stb & recov[0]) | (full_stb & recov[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b0;
      pend <= 1'b0;
      flag <= 1'b0;
      hold <= 1'b0;
    end else begin
      prev <= act;
      if (rise)        flag <= 1'b1;
      else if (clr_ok) flag <= 1'b0;

      if (rise)                    pend <= 1'b1;
      else if (!manual && !act)    pend <= 1'b0;
      else if (manual && clr_ok)   pend <= 1'b0;

      if (rise || pend) hold <= 1'b1;
      else if (boundary) hold <= 1'b0;
    end
  end

  assign off = hold | (comb_en & raw_act);
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
  parameter int NF    = 4,
  parameter int PER_W = 8,
  parameter int CNT_W = 3,
  localparam int DW   = (2*NF > PER_W+CNT_W) ? 2*NF : PER_W+CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] fault_in,
  input  logic          half_stb,
  input  logic          full_stb,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [NF-1:0] fault_off,
  output logic [NF-1:0] fault_flag,
  output logic          fault_irq
);
  logic [NF-1:0]      level, comb_en, ien, flag_clr, raw_act, filt_act, hold_q;
  logic [NF-1:0][1:0] mode, recov;
  logic [PER_W-1:0]   period, per_cnt;
  logic [CNT_W-1:0]   need;
  logic               filt_wr, bypass, tick;

  fpc_regs #(.NF(NF), .PER_W(PER_W), .CNT_W(CNT_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .level(level), .mode(mode), .recov(recov), .comb_en(comb_en), .ien(ien),
    .period(period), .need(need), .filt_wr(filt_wr), .flag_clr(flag_clr)
  );

  assign bypass = (period == '0);
  assign tick   = !bypass && (per_cnt == period - PER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || filt_wr || bypass || tick) per_cnt <= '0;
    else                                      per_cnt <= per_cnt + 1'b1;
  end

  assign raw_act = ~(fault_in ^ level);

  for (genvar i = 0; i < NF; i++) begin : g_fault
    fpc_filter #(.CNT_W(CNT_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_act(raw_act[i]), .tick(tick),
      .bypass(bypass), .clr(filt_wr), .need(need), .act(filt_act[i])
    );
    fpc_latch u_latch (
      .clk(clk), .rst_n(rst_n), .act(filt_act[i]), .raw_act(raw_act[i]),
      .comb_en(comb_en[i]), .mode(mode[i]), .recov(recov[i]), .clr(flag_clr[i]),
      .half_stb(half_stb), .full_stb(full_stb),
      .flag(fault_flag[i]), .hold(hold_q[i]), .off(fault_off[i])
    );
  end

  assign fault_irq = |(fault_flag & ien);
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int NF = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          half_stb,
  input logic          full_stb,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [NF-1:0] flags,
  input logic [NF-1:0] hold,
  input logic          irq
);
  a_r7_release_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(hold) & ~hold)) |-> $past(half_stb | full_stb));

  a_r2_new_flag_disables: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags)) & ~hold) == '0);

  a_r3_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags) & ~flags)) |-> $past(wr_en && wr_addr == 3'd6));

  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|flags));
endmodule

bind pwm_fault_guard fpc_checker #(.NF(NF)) u_chk (
  .clk(clk), .rst_n(rst_n), .half_stb(half_stb), .full_stb(full_stb),
  .wr_en(wr_en), .wr_addr(wr_addr), .flags(fault_flag), .hold(hold_q), .irq(fault_irq)
);

// File: tb/pwm_fault_guard_test.sv
`timescale 1ns/1ps
module pwm_fault_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  fault_in = '0;
  logic        half_stb = 1'b0, full_stb = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [10:0] wr_data = '0;
  logic [3:0]  fault_off, fault_flag;
  logic        fault_irq;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_fault_guard uut (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .half_stb(half_stb), .full_stb(full_stb),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fault_off(fault_off), .fault_flag(fault_flag), .fault_irq(fault_irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [10:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_half();
    @(negedge clk); half_stb = 1'b1;
    @(negedge clk); half_stb = 1'b0;
  endtask

  task automatic pulse_full();
    @(negedge clk); full_stb = 1'b1;
    @(negedge clk); full_stb = 1'b0;
  endtask

  task automatic cleanup();
    fault_in = '0;
    wr(3'd0, 11'h00F); wr(3'd1, 11'h000); wr(3'd2, 11'h0FF);
    wr(3'd3, 11'h000); wr(3'd4, 11'h000); wr(3'd5, 11'h000);
    waitc(8);
    pulse_full();
    wr(3'd6, 11'h00F);
    waitc(2);
  endtask

  task automatic t_reset();
    chk("R2 reset off", fault_off, 4'h0);
    chk("R3 reset flags", fault_flag, 4'h0);
    chk("R11 reset irq", fault_irq, 1'b0);
  endtask

  task automatic t_auto();
    wr(3'd2, 11'h0FE);
    @(negedge clk); fault_in[0] = 1'b1;
    waitc(2);
    chk("R2 not before third edge", fault_flag[0], 1'b0);
    waitc(1);
    chk("R2 flag set", fault_flag[0], 1'b1);
    chk("R2 off set", fault_off[0], 1'b1);
    fault_in[0] = 1'b0;
    waitc(5);
    chk("R4 waits boundary", fault_off[0], 1'b1);
    pulse_half();
    chk("R7 half ignored in full mode", fault_off[0], 1'b1);
    pulse_full();
    chk("R4 auto release on full", fault_off[0], 1'b0);
    chk("R3 flag persists", fault_flag[0], 1'b1);
    wr(3'd6, 11'h00E);
    chk("R3 zero bit no effect", fault_flag[0], 1'b1);
    wr(3'd6, 11'h001);
    chk("R3 one clears", fault_flag[0], 1'b0);
    cleanup();
  endtask

  task automatic t_level();
    fault_in[1] = 1'b1;
    waitc(4);
    pulse_full(); wr(3'd6, 11'h00F);
    wr(3'd0, 11'h00D);
    waitc(5);
    chk("R1 high pin idle when low-active", fault_flag[1], 1'b0);
    fault_in[1] = 1'b0;
    waitc(4);
    chk("R1 low pin faults", fault_flag[1], 1'b1);
    chk("R1 low pin disables", fault_off[1], 1'b1);
    cleanup();
  endtask

  task automatic t_manual();
    wr(3'd1, 11'h001);
    @(negedge clk); fault_in[0] = 1'b1;
    waitc(4); fault_in[0] = 1'b0;
    waitc(5);
    pulse_full(); pulse_half();
    chk("R5 release alone keeps off", fault_off[0], 1'b1);
    wr(3'd6, 11'h001);
    pulse_full();
    chk("R5 clear then boundary", fault_off[0], 1'b0);
    // clear while still active
    wr(3'd1, 11'h004);
    @(negedge clk); fault_in[1] = 1'b1;
    waitc(4);
    wr(3'd6, 11'h002);
    chk("R5 clear while active", fault_flag[1], 1'b0);
    pulse_full();
    chk("R5 off drops while active", fault_off[1], 1'b0);
    cleanup();
  endtask

  task automatic t_safe();
    wr(3'd1, 11'h020);
    @(negedge clk); fault_in[2] = 1'b1;
    waitc(4);
    wr(3'd6, 11'h004);
    chk("R6 clear ignored flag", fault_flag[2], 1'b1);
    pulse_full();
    chk("R6 clear ignored off", fault_off[2], 1'b1);
    fault_in[2] = 1'b0;
    waitc(4);
    pulse_full();
    chk("R6 still off without clear", fault_off[2], 1'b1);
    wr(3'd6, 11'h004);
    chk("R6 clear accepted", fault_flag[2], 1'b0);
    pulse_full();
    chk("R6 release", fault_off[2], 1'b0);
    cleanup();
  endtask

  task automatic t_recovery();
    wr(3'd2, 11'h03F);
    @(negedge clk); fault_in[3] = 1'b1;
    waitc(4); fault_in[3] = 1'b0;
    waitc(5);
    pulse_half(); pulse_full();
    chk("R7 none keeps off", fault_off[3], 1'b1);
    wr(3'd2, 11'h07F);
    pulse_full();
    chk("R7 half-only ignores full", fault_off[3], 1'b1);
    pulse_half();
    chk("R7 half releases", fault_off[3], 1'b0);
    wr(3'd2, 11'h0FF);
    @(negedge clk); fault_in[0] = 1'b1;
    waitc(4); fault_in[0] = 1'b0;
    waitc(5);
    pulse_full();
    chk("R7 both: full releases", fault_off[0], 1'b0);
    cleanup();
  endtask

  task automatic t_comb();
    wr(3'd3, 11'h001);
    @(negedge clk); fault_in[0] = 1'b1; fault_in[2] = 1'b1;
    #1;
    chk("R10 comb path immediate", fault_off[0], 1'b1);
    chk("R10 no comb path no immediate", fault_off[2], 1'b0);
    cleanup();
  endtask

  task automatic t_filter();
    wr(3'd5, 11'h204);
    @(negedge clk); fault_in[0] = 1'b1;
    waitc(5); fault_in[0] = 1'b0;
    waitc(20);
    chk("R8 glitch rejected flag", fault_flag[0], 1'b0);
    chk("R8 glitch rejected off", fault_off[0], 1'b0);
    fault_in[0] = 1'b1;
    waitc(30);
    chk("R8 long fault passes", fault_flag[0], 1'b1);
    wr(3'd6, 11'h001);
    waitc(30);
    chk("R9 no new event without rewrite", fault_flag[0], 1'b0);
    wr(3'd5, 11'h204);
    waitc(30);
    chk("R9 rewrite re-detects", fault_flag[0], 1'b1);
    cleanup();
  endtask

  task automatic t_irq();
    wr(3'd4, 11'h008);
    @(negedge clk); fault_in[2] = 1'b1;
    waitc(4);
    chk("R11 disabled source no irq", fault_irq, 1'b0);
    fault_in[3] = 1'b1;
    waitc(4);
    chk("R11 irq raised", fault_irq, 1'b1);
    wr(3'd6, 11'h008);
    chk("R11 irq drops with flag", fault_irq, 1'b0);
    cleanup();
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog got=hung exp=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    waitc(3);
    rst_n = 1'b1;
    waitc(1);
    t_reset();
    t_auto();
    t_level();
    t_manual();
    t_safe();
    t_recovery();
    t_comb();
    t_filter();
    t_irq();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule